// File: doc/BRIEF.md
# LCD Frame Timing Generator

This block turns a stream of clock-enable ticks into the frame and row-phase timing of a multiplexed LCD driver. One frame always lasts a fixed number of ticks: a large ratio in normal mode and a ratio six times smaller in power-saving mode. Both ratios are chosen so that the frame rate lands near 64 Hz for the tick rate used in each mode. The drive mode selects how many backplane phases share that frame: one, two, three or four.

The block reports the current phase index. It also gives a one-clock strobe when a frame begins and a one-clock strobe just before each phase ends, so the column data for the next phase can be moved into the display latch in time. Several instances can be cascaded. The master pulses an active-low sync line at every frame start, and each follower restarts its counters when it sees that pulse, so all devices show the same backplane phase in the same clock.

A change to the mode or drive-mode inputs is held back until the current frame has finished, so no frame is ever cut short. With no ticks the block stops where it is. That leaves the LCD in a DC state, so the system must keep the ticks running.

Top module: `lcd_frame_timer`

## Requirements
- R1: With save_mode=0, consecutive frame_start pulses are exactly RATIO_NORMAL ticks apart.
- R2: With save_mode=1, consecutive frame_start pulses are exactly RATIO_SAVE ticks apart.
- R3: The drive_mode code gives the phase count N: 0 gives 1, 1 gives 2, 2 gives 3 and 3 gives 4. Each phase lasts floor(R/N) ticks, except the last one (index N-1), which takes the remainder of the R-tick frame. phase_idx shows the phase of the current tick position.
- R4: frame_start is high for exactly one clock, in the clock after the counters move onto phase 0, count 0. It does not pulse on the way out of reset.
- R5: col_load is high for exactly one clock, in the clock after the counters move onto the last tick of any phase.
- R6: While tick_en is low and no resync occurs, phase_idx holds and neither strobe fires.
- R7: New save_mode or drive_mode values take effect only when the frame wraps. The frame already running finishes with its old lengths.
- R8: A master (is_master=1) drives sync_out_n low in exactly the clocks where frame_start is high. A follower keeps sync_out_n high.
- R9: A follower that samples sync_in low at a clock edge restarts at phase 0, count 0 with the current config. If a tick occurs at that same edge, the restart position is advanced by that one tick. As a result, a follower fed by a master tracks the master's phase_idx, frame_start and col_load from then on.
- R10: Synchronous reset sets phase_idx to 0, clears both strobes, drives sync_out_n high and loads the config from the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timing tick; the counters advance only in clocks where it is high |
| save_mode | input | 1 | 0 selects the normal ratio, 1 the power-saving ratio |
| drive_mode | input | 2 | Multiplex selection: 0 static, 1 two phases, 2 three phases, 3 four phases |
| is_master | input | 1 | 1: this instance drives sync; 0: it follows sync_in |
| sync_in | input | 1 | Active-low frame sync from the master (used by followers) |
| phase_idx | output | 2 | Current backplane phase |
| frame_start | output | 1 | One-clock strobe at the start of each frame |
| col_load | output | 1 | One-clock strobe on the last tick of each phase |
| sync_out_n | output | 1 | Active-low frame sync pulse (master only) |

## Verification
The bench uses a small configuration with ratios of 24 and 8. With a ratio of 8, the three-phase mode splits as 2, 2, 4, so a design that rounds every phase equally would show a frame of the wrong length or a phase index that stays too long. It steps through all eight mode codes in the middle of frames, first with ticks on every clock and then with ticks skipped. A design that switches config as soon as the inputs change would shorten the frame in progress, and a design that counts clocks instead of ticks would drift. A long gap with no ticks exposes any strobe that fires while the counters are frozen. A follower is released out of step with the master. If the follower reloads at the wrong count, or ignores the master's sync pulse, it stays one tick or a whole offset out of alignment with the master.

// File: rtl/lcd_ft_pkg.sv
package lcd_ft_pkg;

  typedef enum logic [1:0] {
    DRV_STATIC = 2'd0,
    DRV_MUX2   = 2'd1,
    DRV_MUX3   = 2'd2,
    DRV_MUX4   = 2'd3
  } drive_e;

  typedef struct packed {
    logic   save;
    drive_e drive;
  } ft_cfg_t;

  // Ticks in one phase: the last phase absorbs the division remainder.
  function automatic int unsigned seg_len(int unsigned ratio, int unsigned nph, bit is_last);
    int unsigned q;
    q = ratio / nph;
    return is_last ? (ratio - (nph - 1) * q) : q;
  endfunction

endpackage

// File: rtl/lcd_ft_len.sv
module lcd_ft_len
  import lcd_ft_pkg::*;
#(
  parameter int unsigned RATIO_NORMAL = 2880,
  parameter int unsigned RATIO_SAVE   = 480,
  parameter int unsigned CW           = 12
) (
  input  ft_cfg_t         cfg,
  input  logic [1:0]      phase,
  output logic [CW-1:0]   len
);

  localparam int unsigned NCFG = 8;

  logic [CW-1:0] base_tab [NCFG];
  logic [CW-1:0] tail_tab [NCFG];
  logic [2:0]    idx;

  generate
    for (genvar g = 0; g < NCFG; g++) begin : g_tab
      localparam int unsigned R = (g >= 4) ? RATIO_SAVE : RATIO_NORMAL;
      localparam int unsigned N = (g % 4) + 1;
      assign base_tab[g] = CW'(seg_len(R, N, 1'b0));
      assign tail_tab[g] = CW'(seg_len(R, N, 1'b1));
    end
  endgenerate

  assign idx = cfg;
  // Drive code equals the index of the final phase.
  assign len = (phase == cfg.drive) ? tail_tab[idx] : base_tab[idx];

endmodule

// File: rtl/lcd_ft_seq.sv
module lcd_ft_seq
  import lcd_ft_pkg::*;
#(
  parameter int unsigned RATIO_NORMAL = 2880,
  parameter int unsigned RATIO_SAVE   = 480,
  parameter int unsigned CW           = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       resync,
  input  ft_cfg_t    cfg_in,
  output logic [1:0] phase_nx,
  output logic       moved,
  output logic       nx_start,
  output logic       nx_last
);

  logic [1:0]    phase_q;
  logic [CW-1:0] cnt_q, cnt_nx;
  ft_cfg_t       cfg_q, cfg_nx;
  logic [CW-1:0] len_cur, len_rs, len_nx;

  lcd_ft_len #(.RATIO_NORMAL(RATIO_NORMAL), .RATIO_SAVE(RATIO_SAVE), .CW(CW)) u_len_cur (
    .cfg(cfg_q), .phase(phase_q), .len(len_cur));

  lcd_ft_len #(.RATIO_NORMAL(RATIO_NORMAL), .RATIO_SAVE(RATIO_SAVE), .CW(CW)) u_len_rs (
    .cfg(cfg_in), .phase(2'd0), .len(len_rs));

  lcd_ft_len #(.RATIO_NORMAL(RATIO_NORMAL), .RATIO_SAVE(RATIO_SAVE), .CW(CW)) u_len_nx (
    .cfg(cfg_nx), .phase(phase_nx), .len(len_nx));

  always_comb begin
    phase_nx = phase_q;
    cnt_nx   = cnt_q;
    cfg_nx   = cfg_q;
    if (resync) begin
      cfg_nx   = cfg_in;
      phase_nx = 2'd0;
      cnt_nx   = '0;
      if (tick) begin
        if (len_rs == CW'(1)) begin
          phase_nx = (cfg_in.drive == DRV_STATIC) ? 2'd0 : 2'd1;
        end else begin
          cnt_nx = CW'(1);
        end
      end
    end else if (tick) begin
      if (cnt_q == len_cur - CW'(1)) begin
        cnt_nx = '0;
        if (phase_q == cfg_q.drive) begin
          phase_nx = 2'd0;
          cfg_nx   = cfg_in;
        end else begin
          phase_nx = phase_q + 2'd1;
        end
      end else begin
        cnt_nx = cnt_q + CW'(1);
      end
    end
  end

  always_comb begin
    moved    = (phase_nx != phase_q) || (cnt_nx != cnt_q);
    nx_start = (phase_nx == 2'd0) && (cnt_nx == '0);
    nx_last  = (cnt_nx == len_nx - CW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 2'd0;
      cnt_q   <= '0;
      cfg_q   <= cfg_in;
    end else begin
      phase_q <= phase_nx;
      cnt_q   <= cnt_nx;
      cfg_q   <= cfg_nx;
    end
  end

endmodule

// File: rtl/lcd_ft_strobe.sv
module lcd_ft_strobe (
  input  logic       clk,
  input  logic       rst,
  input  logic       is_master,
  input  logic       moved,
  input  logic       nx_start,
  input  logic       nx_last,
  input  logic [1:0] phase_nx,
  output logic [1:0] phase_idx,
  output logic       frame_start,
  output logic       col_load,
  output logic       sync_out_n
);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_idx   <= 2'd0;
      frame_start <= 1'b0;
      col_load    <= 1'b0;
      sync_out_n  <= 1'b1;
    end else begin
      phase_idx   <= phase_nx;
      frame_start <= moved && nx_start;
      col_load    <= moved && nx_last;
      sync_out_n  <= !(is_master && moved && nx_start);
    end
  end

endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
  import lcd_ft_pkg::*;
#(
  parameter int unsigned RATIO_NORMAL = 2880,
  parameter int unsigned RATIO_SAVE   = 480
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       save_mode,
  input  logic [1:0] drive_mode,
  input  logic       is_master,
  input  logic       sync_in,
  output logic [1:0] phase_idx,
  output logic       frame_start,
  output logic       col_load,
  output logic       sync_out_n
);

  localparam int unsigned RMAX = (RATIO_NORMAL > RATIO_SAVE) ? RATIO_NORMAL : RATIO_SAVE;
  localparam int unsigned CW   = $clog2(RMAX + 1);

  ft_cfg_t    cfg_in;
  logic       resync;
  logic [1:0] phase_nx;
  logic       moved, nx_start, nx_last;

  assign cfg_in = '{save: save_mode, drive: drive_e'(drive_mode)};
  assign resync = !is_master && !sync_in;

  lcd_ft_seq #(.RATIO_NORMAL(RATIO_NORMAL), .RATIO_SAVE(RATIO_SAVE), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .tick(tick_en), .resync(resync), .cfg_in(cfg_in),
    .phase_nx(phase_nx), .moved(moved), .nx_start(nx_start), .nx_last(nx_last));

  lcd_ft_strobe u_strobe (
    .clk(clk), .rst(rst), .is_master(is_master), .moved(moved), .nx_start(nx_start),
    .nx_last(nx_last), .phase_nx(phase_nx), .phase_idx(phase_idx),
    .frame_start(frame_start), .col_load(col_load), .sync_out_n(sync_out_n));

endmodule

// File: rtl/lcd_frame_timer_chk.sv
module lcd_frame_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_en,
  input logic       is_master,
  input logic       sync_in,
  input logic [1:0] phase_idx,
  input logic       frame_start,
  input logic       col_load,
  input logic       sync_out_n
);

  a_r4_start_phase0: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (phase_idx == 2'd0));

  a_r4_start_single: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  a_r5_load_single: assert property (@(posedge clk) disable iff (rst)
    col_load |=> !col_load);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && (is_master || sync_in)) |=> ($stable(phase_idx) && !frame_start && !col_load));

  a_r8_master_sync: assert property (@(posedge clk) disable iff (rst)
    (is_master && $past(is_master)) |-> (sync_out_n == !frame_start));

  a_r8_follower_quiet: assert property (@(posedge clk) disable iff (rst)
    (!is_master && !$past(is_master)) |-> sync_out_n);

endmodule

bind lcd_frame_timer lcd_frame_timer_chk u_chk (.*);

// File: tb/lcd_frame_timer_tb_top.sv
module lcd_frame_timer_tb_top;

  localparam int RN = 24;
  localparam int RS = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1, rst_f = 1'b1, tick_en = 1'b0, save_mode = 1'b0;
  logic [1:0] drive_mode = 2'd0;
  logic [1:0] m_phase, f_phase;
  logic       m_fs, m_cl, m_sync, f_fs, f_cl, f_sync;

  lcd_frame_timer #(.RATIO_NORMAL(RN), .RATIO_SAVE(RS)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .save_mode(save_mode), .drive_mode(drive_mode),
    .is_master(1'b1), .sync_in(1'b1), .phase_idx(m_phase), .frame_start(m_fs),
    .col_load(m_cl), .sync_out_n(m_sync));

  lcd_frame_timer #(.RATIO_NORMAL(RN), .RATIO_SAVE(RS)) dut_f (
    .clk(clk), .rst(rst_f), .tick_en(tick_en), .save_mode(save_mode), .drive_mode(drive_mode),
    .is_master(1'b0), .sync_in(m_sync), .phase_idx(f_phase), .frame_start(f_fs),
    .col_load(f_cl), .sync_out_n(f_sync));

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int ratio_of(int s);
    return s ? RS : RN;
  endfunction

  function automatic int phase_of(int t, int s, int d);
    int n, q, p;
    n = d + 1;
    q = ratio_of(s) / n;
    p = t / q;
    return (p > n - 1) ? n - 1 : p;
  endfunction

  function automatic bit last_of(int t, int s, int d);
    int n, q, p;
    n = d + 1;
    q = ratio_of(s) / n;
    p = phase_of(t, s, d);
    return (p < n - 1) ? ((t % q) == q - 1) : (t == ratio_of(s) - 1);
  endfunction

  // Arithmetic model of the master: tick position inside the frame.
  int t = 0, ms = 0, md = 0;
  bit e_fs = 0, e_cl = 0, chk_model = 0;

  always @(posedge clk) begin
    if (rst) begin
      t = 0; ms = save_mode; md = drive_mode; e_fs = 0; e_cl = 0;
    end else if (tick_en) begin
      if (t == ratio_of(ms) - 1) begin
        t = 0; ms = save_mode; md = drive_mode; e_fs = 1;
      end else begin
        t = t + 1; e_fs = 0;
      end
      e_cl = last_of(t, ms, md);
    end else begin
      e_fs = 0; e_cl = 0;
    end
  end

  always @(negedge clk) begin
    if (chk_model && !rst) begin
      check("R3/R7 phase_idx", m_phase, phase_of(t, ms, md));
      check(ms ? "R2/R4 frame_start" : "R1/R4 frame_start", m_fs, e_fs);
      check("R5 col_load", m_cl, e_cl);
      check("R8 master sync", m_sync, !e_fs);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    check("R10 reset phase", m_phase, 0);
    check("R10 reset frame_start", m_fs, 0);
    check("R10 reset col_load", m_cl, 0);
    check("R10 reset sync", m_sync, 1);
    rst = 1'b0;
    chk_model = 1;
    // Config sweep, changed mid-frame each time (R7), all codes (R3).
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < 8; k++) begin
        save_mode  = k[2];
        drive_mode = k[1:0];
        for (int c = 0; c < 61; c++) begin
          tick_en = (pass == 0) ? 1'b1 : ((c % 3) != 0);
          @(negedge clk);
        end
      end
    end
    // Frozen tick stream (R6): DC-hold hazard on a real panel.
    tick_en = 1'b0;
    @(negedge clk);
    held = m_phase;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      check("R6 phase held", m_phase, held);
      check("R6 no frame_start", m_fs, 0);
      check("R6 no col_load", m_cl, 0);
    end
    $display("note: tick stream stopped for 20 clocks, display would sit in DC");
    // Cascade (R9): follower released out of step with the master.
    save_mode = 1'b0; drive_mode = 2'd3; tick_en = 1'b1;
    repeat (7) @(negedge clk);
    rst_f = 1'b0;
    repeat (3 * RN) @(negedge clk);
    for (int c = 0; c < 2 * RN; c++) begin
      @(negedge clk);
      check("R9 follower phase", f_phase, m_phase);
      check("R9 follower frame_start", f_fs, m_fs);
      check("R9 follower col_load", f_cl, m_cl);
      check("R8 follower sync high", f_sync, 1);
    end
    chk_model = 0;
    finish_run();
  end

endmodule